// File: doc/BRIEF.md
# Error Message Signaling Controller

This block sits beside a device's error detectors and decides, cycle by cycle, which error messages must travel toward the root of the fabric. Each cycle it takes one-cycle pulses for every uncorrectable and correctable error type, together with the per-type mask and severity vectors and four reporting-enable bits. It sorts the events into three message classes: fatal, non-fatal and correctable. Every message is tagged with the device's requester ID as it stood when the event was detected.

Pending messages are kept as one slot per class, so at most three messages wait at any time. They leave over a valid/ready stream toward a packet builder. The builder may hold `msg_ready` low for as long as it likes. While it does, `msg_valid`, `msg_code` and `msg_src` stay frozen on the message already offered, and a new event of the same class is merged into the message that is already waiting. Once nothing is being offered, the highest class waiting is offered next: fatal first, then non-fatal, then correctable.

An advisory flag lets the detector downgrade the non-fatal events of that cycle to a correctable advisory message. This path exists only when the `ROLE_BASED` parameter is set.

Top module: `emsg_ctrl`

## Requirements
- R1: A fatal message carries code 8'h33, a non-fatal message 8'h31 and a correctable message 8'h30. `msg_src` equals the `req_id` value sampled in the cycle of the event that created the message.
- R2: `rpt_en` bit 0 gates correctable messages, bit 1 gates non-fatal messages and bit 2 gates fatal messages. When the relevant bit is clear, an event of that class produces no message.
- R3: An event on the unsupported-request type (`unc_evt` bit `UR_BIT`, default 20) produces a message only when `rpt_en` bit 3 is set. When bit 3 is clear it produces none.
- R4: A set bit in `unc_mask` or `cor_mask` stops that error type from producing any message.
- R5: An unmasked uncorrectable event produces a fatal message when its `unc_sev` bit is 1 and a non-fatal message when that bit is 0.
- R6: With `ROLE_BASED`=1 and `adv_flag` high, the non-fatal events of that cycle produce a correctable message (8'h30) instead of a non-fatal one. This advisory message is gated by `rpt_en` bit 0 and suppressed by `cor_mask` bit `ADV_BIT` (default 13). Fatal events are not affected by `adv_flag`.
- R7: `msg_valid` rises in the cycle after the clock edge that samples the event. With no event and nothing pending, `msg_valid` stays low.
- R8: When messages of several classes are waiting, they are offered fatal first, then non-fatal, then correctable. Each class is offered once.
- R9: While a message of one class is waiting, further events of that class add no second message. The waiting message keeps its original source ID. An event that arrives in the same cycle as the handshake for its class re-arms that class with the new source ID.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_code` and `msg_src` hold their values, even if a higher class arrives. A message is removed only on a clock edge where both `msg_valid` and `msg_ready` are high.
- R11: Reset (`rst_n` low, asynchronous) clears every waiting message, and `msg_valid` is low from reset onward until a new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unc_evt | input | UNC_W | Uncorrectable error detection pulses, one bit per type |
| unc_mask | input | UNC_W | Per-type message suppression for uncorrectable errors |
| unc_sev | input | UNC_W | Per-type severity, 1 = fatal, 0 = non-fatal |
| cor_evt | input | COR_W | Correctable error detection pulses, one bit per type |
| cor_mask | input | COR_W | Per-type message suppression for correctable errors |
| rpt_en | input | 4 | Reporting enables: [0] correctable, [1] non-fatal, [2] fatal, [3] unsupported request |
| adv_flag | input | 1 | Treat this cycle's non-fatal events as advisory |
| req_id | input | SRC_W | Requester ID of this device |
| msg_ready | input | 1 | Packet builder accepts the offered message |
| msg_valid | output | 1 | A message is offered |
| msg_code | output | 8 | Message code of the offered message |
| msg_src | output | SRC_W | Source ID of the offered message |

## Verification
An event driven before a clock edge is sampled on that edge. Its message is therefore due on the ports in the next cycle, and the bench samples on the falling edge that follows. The first message of each vector is checked there with `msg_ready` held low. Each later message is checked one cycle after the edge on which `msg_ready` was high, because a handshake frees the slot for the next message in that same cycle. The cycle before the sampling edge is also checked, to confirm that `msg_valid` does not rise early. For the hold and merge cases, the output is sampled on several consecutive cycles while `msg_ready` is low.

// File: rtl/emsg_pkg.sv
package emsg_pkg;
  typedef enum logic [1:0] {
    CLS_FATAL = 2'd0,
    CLS_NF    = 2'd1,
    CLS_COR   = 2'd2
  } msg_cls_e;

  localparam int NUM_CLS = 3;

  localparam logic [7:0] CODE_COR   = 8'h30;
  localparam logic [7:0] CODE_NF    = 8'h31;
  localparam logic [7:0] CODE_FATAL = 8'h33;

  function automatic logic [7:0] cls_code(input msg_cls_e c);
    case (c)
      CLS_FATAL: cls_code = CODE_FATAL;
      CLS_NF:    cls_code = CODE_NF;
      default:   cls_code = CODE_COR;
    endcase
  endfunction
endpackage

// File: rtl/emsg_classify.sv
module emsg_classify #(
  parameter int UNC_W      = 26,
  parameter int COR_W      = 16,
  parameter int UR_BIT     = 20,
  parameter int ADV_BIT    = 13,
  parameter bit ROLE_BASED = 1'b1
) (
  input  logic [UNC_W-1:0] unc_evt,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [UNC_W-1:0] unc_sev,
  input  logic [COR_W-1:0] cor_evt,
  input  logic [COR_W-1:0] cor_mask,
  input  logic [3:0]       rpt_en,
  input  logic             adv_flag,
  output logic [emsg_pkg::NUM_CLS-1:0] set_cls
);
  import emsg_pkg::*;

  // Per-type qualification: mask, then the extra gate on the unsupported-request type
  logic [UNC_W-1:0] unc_live;

  for (genvar i = 0; i < UNC_W; i++) begin : g_qual
    if (i == UR_BIT) begin : g_ur
      assign unc_live[i] = unc_evt[i] & ~unc_mask[i] & rpt_en[3];
    end else begin : g_plain
      assign unc_live[i] = unc_evt[i] & ~unc_mask[i];
    end
  end

  logic any_fatal, any_nf, any_cor, adv_on, adv_cor;

  always_comb begin
    any_fatal = |(unc_live & unc_sev);
    any_nf    = |(unc_live & ~unc_sev);
    any_cor   = |(cor_evt & ~cor_mask);
    adv_on    = ROLE_BASED & adv_flag;
    adv_cor   = any_nf & adv_on & ~cor_mask[ADV_BIT];

    set_cls            = '0;
    set_cls[CLS_FATAL] = any_fatal & rpt_en[2];
    set_cls[CLS_NF]    = any_nf & ~adv_on & rpt_en[1];
    set_cls[CLS_COR]   = (any_cor | adv_cor) & rpt_en[0];
  end
endmodule

// File: rtl/emsg_slot.sv
module emsg_slot #(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             pop,
  input  logic [SRC_W-1:0] src_in,
  output logic             pend,
  output logic [SRC_W-1:0] src
);
  // Capture a new source only when the slot is free or being freed this cycle
  logic take;
  assign take = set & (~pend | pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      src  <= '0;
    end else begin
      pend <= (pend & ~pop) | set;
      if (take) src <= src_in;
    end
  end
endmodule

// File: rtl/emsg_arb.sv
module emsg_arb #(
  parameter int SRC_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [emsg_pkg::NUM_CLS-1:0]            pend,
  input  logic [emsg_pkg::NUM_CLS-1:0][SRC_W-1:0] srcs,
  input  logic                                    msg_ready,
  output logic [emsg_pkg::NUM_CLS-1:0]            pop,
  output logic                                    msg_valid,
  output logic [7:0]                              msg_code,
  output logic [SRC_W-1:0]                        msg_src
);
  import emsg_pkg::*;

  logic     held_q;
  msg_cls_e held_cls_q;
  msg_cls_e pri_cls, sel;

  // Fixed priority: lowest index (fatal) wins
  always_comb begin
    pri_cls = CLS_COR;
    for (int c = NUM_CLS - 1; c >= 0; c--) begin
      if (pend[c]) pri_cls = msg_cls_e'(c);
    end
  end

  assign sel       = held_q ? held_cls_q : pri_cls;
  assign msg_valid = |pend;
  assign msg_code  = cls_code(sel);
  assign msg_src   = srcs[sel];

  always_comb begin
    pop = '0;
    pop[sel] = msg_valid & msg_ready;
  end

  // Lock the offered class while the consumer stalls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_cls_q <= CLS_FATAL;
    end else begin
      held_q     <= msg_valid & ~msg_ready;
      held_cls_q <= sel;
    end
  end
endmodule

// File: rtl/emsg_ctrl.sv
module emsg_ctrl #(
  parameter int UNC_W      = 26,
  parameter int COR_W      = 16,
  parameter int SRC_W      = 16,
  parameter int UR_BIT     = 20,
  parameter int ADV_BIT    = 13,
  parameter bit ROLE_BASED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UNC_W-1:0] unc_evt,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [UNC_W-1:0] unc_sev,
  input  logic [COR_W-1:0] cor_evt,
  input  logic [COR_W-1:0] cor_mask,
  input  logic [3:0]       rpt_en,
  input  logic             adv_flag,
  input  logic [SRC_W-1:0] req_id,
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [7:0]       msg_code,
  output logic [SRC_W-1:0] msg_src
);
  import emsg_pkg::*;

  logic [NUM_CLS-1:0]            set_cls;
  logic [NUM_CLS-1:0]            pend;
  logic [NUM_CLS-1:0]            pop;
  logic [NUM_CLS-1:0][SRC_W-1:0] srcs;

  emsg_classify #(
    .UNC_W(UNC_W), .COR_W(COR_W), .UR_BIT(UR_BIT),
    .ADV_BIT(ADV_BIT), .ROLE_BASED(ROLE_BASED)
  ) u_classify (
    .unc_evt(unc_evt), .unc_mask(unc_mask), .unc_sev(unc_sev),
    .cor_evt(cor_evt), .cor_mask(cor_mask), .rpt_en(rpt_en),
    .adv_flag(adv_flag), .set_cls(set_cls)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_slot
    emsg_slot #(.SRC_W(SRC_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .set(set_cls[c]), .pop(pop[c]),
      .src_in(req_id), .pend(pend[c]), .src(srcs[c])
    );
  end

  emsg_arb #(.SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .srcs(srcs),
    .msg_ready(msg_ready), .pop(pop), .msg_valid(msg_valid),
    .msg_code(msg_code), .msg_src(msg_src)
  );
endmodule

// File: rtl/emsg_ctrl_chk.sv
module emsg_ctrl_chk #(
  parameter int UNC_W = 26,
  parameter int COR_W = 16,
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UNC_W-1:0] unc_evt,
  input logic [COR_W-1:0] cor_evt,
  input logic             msg_ready,
  input logic             msg_valid,
  input logic [7:0]       msg_code,
  input logic [SRC_W-1:0] msg_src
);
  logic out_of_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_of_rst <= 1'b0;
    else        out_of_rst <= 1'b1;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_code) && $stable(msg_src)));

  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_code == 8'h30 || msg_code == 8'h31 || msg_code == 8'h33));

  // R7
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && unc_evt == '0 && cor_evt == '0) |=> !msg_valid);

  // R11
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_rst |-> !msg_valid);
endmodule

bind emsg_ctrl emsg_ctrl_chk #(.UNC_W(UNC_W), .COR_W(COR_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unc_evt(unc_evt), .cor_evt(cor_evt),
  .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_code(msg_code), .msg_src(msg_src)
);

// File: tb/emsg_ctrl_bench.sv
module emsg_ctrl_bench;
  localparam int UNC_W = 26;
  localparam int COR_W = 16;
  localparam int SRC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [UNC_W-1:0] unc_evt = '0, unc_mask = '0, unc_sev = '0;
  logic [COR_W-1:0] cor_evt = '0, cor_mask = '0;
  logic [3:0]       rpt_en = 4'hF;
  logic             adv_flag = 1'b0;
  logic [SRC_W-1:0] req_id = '0;
  logic             msg_ready = 1'b0;
  logic             msg_valid;
  logic [7:0]       msg_code;
  logic [SRC_W-1:0] msg_src;

  always #2 clk = ~clk;

  emsg_ctrl u_emsg_ctrl (
    .clk(clk), .rst_n(rst_n), .unc_evt(unc_evt), .unc_mask(unc_mask),
    .unc_sev(unc_sev), .cor_evt(cor_evt), .cor_mask(cor_mask),
    .rpt_en(rpt_en), .adv_flag(adv_flag), .req_id(req_id),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_code(msg_code),
    .msg_src(msg_src)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [UNC_W-1:0] unc;
    logic [UNC_W-1:0] sev;
    logic [UNC_W-1:0] umask;
    logic [COR_W-1:0] cor;
    logic [COR_W-1:0] cmask;
    logic [3:0]       en;
    logic             adv;
    logic [1:0]       n;
    logic [23:0]      codes;  // first expected code in [23:16]
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{26'h10,     26'h10,   26'h0,    16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h330000}, // R5 R1
    '{26'h4000,   26'h0,    26'h0,    16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h310000}, // R5
    '{26'h0,      26'h0,    26'h0,    16'h1,  16'h0,    4'hF, 1'b0, 2'd1, 24'h300000}, // R1
    '{26'h10,     26'h0,    26'h0,    16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h310000}, // R5
    '{26'h4000,   26'h4000, 26'h0,    16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h330000}, // R5
    '{26'h4000,   26'h0,    26'h0,    16'h0,  16'h0,    4'hD, 1'b0, 2'd0, 24'h0},      // R2
    '{26'h10,     26'h10,   26'h0,    16'h0,  16'h0,    4'hB, 1'b0, 2'd0, 24'h0},      // R2
    '{26'h0,      26'h0,    26'h0,    16'h40, 16'h0,    4'hE, 1'b0, 2'd0, 24'h0},      // R2
    '{26'h100000, 26'h0,    26'h0,    16'h0,  16'h0,    4'h7, 1'b0, 2'd0, 24'h0},      // R3
    '{26'h100000, 26'h0,    26'h0,    16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h310000}, // R3
    '{26'h4000,   26'h0,    26'h4000, 16'h0,  16'h0,    4'hF, 1'b0, 2'd0, 24'h0},      // R4
    '{26'h0,      26'h0,    26'h0,    16'h80, 16'h80,   4'hF, 1'b0, 2'd0, 24'h0},      // R4
    '{26'h4000,   26'h0,    26'h0,    16'h0,  16'h0,    4'hF, 1'b1, 2'd1, 24'h300000}, // R6
    '{26'h4000,   26'h0,    26'h0,    16'h0,  16'h2000, 4'hF, 1'b1, 2'd0, 24'h0},      // R6
    '{26'h10,     26'h10,   26'h0,    16'h0,  16'h0,    4'hF, 1'b1, 2'd1, 24'h330000}, // R6
    '{26'h4010,   26'h10,   26'h0,    16'h1,  16'h0,    4'hF, 1'b0, 2'd3, 24'h333130}, // R8
    '{26'h5000,   26'h0,    26'h0,    16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h310000}, // R9
    '{26'h5000,   26'h0,    26'h1000, 16'h0,  16'h0,    4'hF, 1'b0, 2'd1, 24'h310000}  // R4
  };

  task automatic clear_evts();
    unc_evt = '0; cor_evt = '0; adv_flag = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk(msg_valid == 1'b0, "R11 valid in reset", msg_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_valid == 1'b0, "R11 valid after reset", msg_valid, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [15:0] id;
      v = VECS[i];
      id = 16'h0100 + 16'(i);
      unc_evt = v.unc; unc_sev = v.sev; unc_mask = v.umask;
      cor_evt = v.cor; cor_mask = v.cmask; rpt_en = v.en;
      adv_flag = v.adv; req_id = id; msg_ready = 1'b0;
      #1;
      chk(msg_valid == 1'b0, "R7 no early valid", msg_valid, 0);
      @(negedge clk);
      clear_evts();
      req_id = 16'hFFFF;
      for (int k = 0; k < int'(v.n); k++) begin
        logic [7:0] ec;
        ec = v.codes[23 - 8*k -: 8];
        chk(msg_valid == 1'b1, $sformatf("R7 R8 vec%0d msg%0d valid", i, k), msg_valid, 1);
        chk(msg_code == ec, $sformatf("R1 R2 R3 R4 R5 R6 R8 vec%0d msg%0d code", i, k), msg_code, ec);
        chk(msg_src == id, $sformatf("R1 vec%0d msg%0d src", i, k), msg_src, id);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
      end
      chk(msg_valid == 1'b0, $sformatf("R2 R3 R4 R6 R9 vec%0d drained", i), msg_valid, 0);
    end

    unc_sev = '0; unc_mask = '0; cor_mask = '0; rpt_en = 4'hF;

    // R10: hold under stall, higher class arriving later waits
    cor_evt = 16'h1; req_id = 16'hA001;
    @(negedge clk);
    clear_evts();
    req_id = 16'hA002;
    repeat (3) begin
      @(negedge clk);
      chk(msg_valid && msg_code == 8'h30 && msg_src == 16'hA001, "R10 hold cor",
          {msg_code, msg_src}, {8'h30, 16'hA001});
    end
    unc_evt = 26'h10; unc_sev = 26'h10; req_id = 16'hB003;
    @(negedge clk);
    clear_evts();
    chk(msg_code == 8'h30 && msg_src == 16'hA001, "R10 no preempt", {msg_code, msg_src}, {8'h30, 16'hA001});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(msg_valid && msg_code == 8'h33 && msg_src == 16'hB003, "R10 R8 fatal after",
        {msg_code, msg_src}, {8'h33, 16'hB003});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(msg_valid == 1'b0, "R10 drained", msg_valid, 0);
    unc_sev = '0;

    // R9: coalesce across cycles, keeps first source
    unc_evt = 26'h4000; req_id = 16'hC001;
    @(negedge clk);
    req_id = 16'hC002;
    @(negedge clk);
    clear_evts();
    chk(msg_src == 16'hC001, "R9 first src kept", msg_src, 16'hC001);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(msg_valid == 1'b0, "R9 single message", msg_valid, 0);

    // R9: event during handshake of its class re-arms with new source
    unc_evt = 26'h4000; req_id = 16'hD001;
    @(negedge clk);
    req_id = 16'hD002; msg_ready = 1'b1;
    @(negedge clk);
    clear_evts(); msg_ready = 1'b0;
    chk(msg_valid && msg_code == 8'h31 && msg_src == 16'hD002, "R9 rearm",
        {msg_code, msg_src}, {8'h31, 16'hD002});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk(msg_valid == 1'b0, "R9 rearm drained", msg_valid, 0);

    // R11: reset with messages waiting
    unc_evt = 26'h4010; unc_sev = 26'h10; cor_evt = 16'h1;
    @(negedge clk);
    clear_evts();
    chk(msg_valid == 1'b1, "R11 pending before reset", msg_valid, 1);
    rst_n = 1'b0;
    #1;
    chk(msg_valid == 1'b0, "R11 async clear", msg_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(msg_valid == 1'b0, "R11 empty after reset", msg_valid, 0);

    finish_run();
  end
endmodule